// File: doc/BRIEF.md
# Speculative Coalescing Store Buffer

This block holds the stores of an out-of-order core between the allocate stage and the data cache. Each cycle the allocate stage offers a group of up to `ALLOC_W` micro-ops in program order. Every store in the group needs a buffer entry. Other micro-ops pass through without one. The block answers in the same cycle with a grant mask, which is always a prefix of the group. If a store cannot get an entry, that store and every younger micro-op in the group are held back, and a stall-cycle counter records the lost cycle. The front end presents the refused micro-ops again in a later cycle.

Stores stay in a circular queue of `DEPTH` entries. The retire stage marks them non-speculative one at a time, oldest first. A branch-misprediction flush discards in one cycle every entry that is not yet retired. Retired entries drain to a cache write port strictly in program order, at most one per cycle, under a valid/ready handshake. An entry becomes free only when its store is accepted by the cache.

When a store retires as the youngest entry and the entry just before it has the same address, the two are merged into that older entry, provided the older entry is not being written to the cache in the same cycle. Because of this merging, one more store than the entry count can be outstanding.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset `alloc_grant` is 0 for an empty group, `cache_wr_valid` is 0 and `stall_cycles` is 0.
- R2: The grant is combinational in the same cycle and is a prefix of the offered slots, where slot 0 is the oldest. Stores take entries in slot order. A micro-op with `alloc_store`=0 is granted whenever every older slot is granted, and it takes no entry.
- R3: At most `DEPTH` stores are held. A store that finds no free entry is refused, and so is every younger slot in the group. Older slots are still granted.
- R4: `stall_cycles` increases by one after each cycle in which a valid store was refused for lack of an entry, and holds in every other cycle.
- R5: `retire_valid` marks the oldest unretired entry as retired. Only retired entries are offered on the cache port, starting on the cycle after the retire edge.
- R6: The cache port presents entries in program order, one per cycle when `cache_wr_ready` is 1. While `cache_wr_ready` is 0, the same address is held.
- R7: An entry released by a cache write in the current cycle can be granted to a store in that same cycle.
- R8: When `flush` is 1, no slot is granted in that cycle, and every entry still unretired after that cycle's retirement is discarded. Retired entries still drain, and discarded entries never reach the cache.
- R9: A store that retires as the youngest entry, with the entry before it at the same address and not being written that cycle, merges into that entry. The merged byte enable is the OR of the two. Bytes enabled by the younger store take its data, and the other bytes keep the older data. The merge produces a single cache write.
- R10: No merge takes place when the addresses differ, or when the older entry is accepted by the cache in the cycle the younger one retires. Both stores are then written separately, with their own byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | ALLOC_W | Slot holds a micro-op; slot 0 is oldest |
| alloc_store | input | ALLOC_W | Slot's micro-op is a store |
| alloc_addr | input | ALLOC_W x ADDR_W | Store address per slot |
| alloc_data | input | ALLOC_W x DATA_W | Store data per slot |
| alloc_be | input | ALLOC_W x BE_W | Store byte enables per slot |
| alloc_grant | output | ALLOC_W | Slots accepted this cycle (prefix) |
| retire_valid | input | 1 | Oldest unretired store becomes non-speculative |
| flush | input | 1 | Misprediction: discard unretired entries |
| cache_wr_valid | output | 1 | Oldest retired entry is offered to the cache |
| cache_wr_addr | output | ADDR_W | Address of offered entry |
| cache_wr_data | output | DATA_W | Data of offered entry |
| cache_wr_be | output | BE_W | Byte enables of offered entry |
| cache_wr_ready | input | 1 | Cache accepts the offered entry |
| stall_cycles | output | STALL_W | Count of allocate cycles lost for lack of entries |

## Verification
The grant mask is due in the same cycle as the group it answers, and it already reflects a cache write being accepted in that cycle. A retired store appears on the cache port one clock edge after its retire cycle, and the next entry appears one edge after each accepted write. The stall counter shows a refusal one edge after the refused cycle. The bench changes inputs on the falling edge and samples 1 ns later, so every check reads the same-cycle grant and the state registered by the previous rising edge.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
// Package sb_pkg
// Shared helpers for the store buffer: modular pointer arithmetic for a
// circular queue whose depth need not be a power of two.
// Assumes the caller passes p < depth and k <= depth.
package sb_pkg;

    // Advance a ring index by k positions.
    function automatic int unsigned ring_add(input int unsigned p,
                                             input int unsigned k,
                                             input int unsigned depth);
        int unsigned s;
        s = p + k;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

    // Step a ring index back by one position.
    function automatic int unsigned ring_dec(input int unsigned p,
                                             input int unsigned depth);
        return (p == 0) ? depth - 1 : p - 1;
    endfunction

endpackage

// File: rtl/sb_alloc_grant.sv
`timescale 1ns/1ps
// Module sb_alloc_grant
// Decides which micro-ops of the allocate group pass this cycle. It walks
// the slots oldest first. Non-stores pass freely. Each store consumes one
// of free_slots. The first refused or empty slot ends the grant, so the
// grant is always a prefix. It also reports each granted store's rank
// among the granted stores, and flags a refusal caused by lack of space.
// Assumes: free_slots already includes an entry released this cycle.
module sb_alloc_grant #(
    parameter int ALLOC_W = 4,
    parameter int CNT_W   = 6,
    parameter int RK_W    = 3
) (
    input  logic [ALLOC_W-1:0]           valid,
    input  logic [ALLOC_W-1:0]           is_store,
    input  logic [CNT_W-1:0]             free_slots,
    input  logic                         block,
    output logic [ALLOC_W-1:0]           grant,
    output logic [ALLOC_W-1:0]           wr_en,
    output logic [ALLOC_W-1:0][RK_W-1:0] wr_rank,
    output logic                         no_space
);

    // Prefix walk over the slots in program order.
    always_comb begin
        logic            ok;
        logic [RK_W-1:0] used;
        ok       = 1'b1;
        used     = '0;
        grant    = '0;
        wr_en    = '0;
        no_space = 1'b0;
        for (int i = 0; i < ALLOC_W; i++) begin
            wr_rank[i] = used;
            if (ok && valid[i] && !block) begin
                if (!is_store[i]) begin
                    grant[i] = 1'b1;
                end else if (CNT_W'(used) < free_slots) begin
                    grant[i] = 1'b1;
                    wr_en[i] = 1'b1;
                    used     = used + 1'b1;
                end else begin
                    ok       = 1'b0;
                    no_space = 1'b1;
                end
            end else begin
                ok = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sb_entry_queue.sv
`timescale 1ns/1ps
// Module sb_entry_queue
// Circular queue of store entries with three pointers. head is the oldest
// entry (next to drain), rptr is the oldest unretired entry and tail is the
// next free entry. Two occupancy counters sit next to them, so full and
// empty stay unambiguous for any depth. The queue handles allocation
// writes, in-order retirement, flush of unretired entries, in-order drain
// and merging of a retiring youngest store into its same-address
// predecessor.
// Assumes: retire_valid only when an unretired entry exists, and a
// wr_en count never above the free_slots this block reports.
module sb_entry_queue #(
    parameter int DEPTH   = 42,
    parameter int ALLOC_W = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int BE_W    = DATA_W / 8,
    parameter int PTR_W   = 6,
    parameter int CNT_W   = 6,
    parameter int RK_W    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ALLOC_W-1:0]             wr_en,
    input  logic [ALLOC_W-1:0][RK_W-1:0]   wr_rank,
    input  logic [ALLOC_W-1:0][ADDR_W-1:0] wr_addr,
    input  logic [ALLOC_W-1:0][DATA_W-1:0] wr_data,
    input  logic [ALLOC_W-1:0][BE_W-1:0]   wr_be,
    input  logic                           retire_valid,
    input  logic                           flush,
    input  logic                           drain_ready,
    output logic [CNT_W-1:0]               free_slots,
    output logic                           drain_valid,
    output logic [ADDR_W-1:0]              drain_addr,
    output logic [DATA_W-1:0]              drain_data,
    output logic [BE_W-1:0]                drain_be
);
    import sb_pkg::*;

    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [BE_W-1:0]   e_be   [DEPTH];

    logic [PTR_W-1:0] head, rptr, tail;
    logic [PTR_W-1:0] head_n, rptr_n, tail_n;
    logic [CNT_W-1:0] cnt, rcnt;
    logic [CNT_W-1:0] cnt_n, rcnt_n;

    logic              drain_fire, merge_en;
    logic [PTR_W-1:0]  older_idx, base_idx;
    logic [RK_W-1:0]   n_alloc;
    logic [PTR_W-1:0]  slot_idx [ALLOC_W];
    logic [DATA_W-1:0] merged_data;

    // Drain side: oldest retired entry, and credit for a same-cycle release.
    always_comb begin
        drain_valid = (rcnt != '0);
        drain_fire  = drain_valid && drain_ready;
        drain_addr  = e_addr[head];
        drain_data  = e_data[head];
        drain_be    = e_be[head];
        free_slots  = CNT_W'(DEPTH) - cnt + CNT_W'(drain_fire);
    end

    // Merge check: the retiring store is the youngest entry and matches its predecessor.
    always_comb begin
        older_idx = PTR_W'(ring_dec(32'(rptr), DEPTH));
        merge_en  = retire_valid && (cnt - rcnt == CNT_W'(1)) && (rcnt != '0)
                    && !(older_idx == head && drain_fire)
                    && (e_addr[rptr] == e_addr[older_idx]);
        base_idx  = merge_en ? PTR_W'(ring_dec(32'(tail), DEPTH)) : tail;
    end

    // Byte-wise merge: younger bytes replace older ones where enabled.
    for (genvar b = 0; b < BE_W; b++) begin : g_merge_byte
        assign merged_data[b*8 +: 8] = e_be[rptr][b] ? e_data[rptr][b*8 +: 8]
                                                     : e_data[older_idx][b*8 +: 8];
    end

    // Target entry of each allocating slot, and the number of stores written.
    always_comb begin
        n_alloc = '0;
        for (int j = 0; j < ALLOC_W; j++) begin
            slot_idx[j] = PTR_W'(ring_add(32'(base_idx), 32'(wr_rank[j]), DEPTH));
            n_alloc     = n_alloc + RK_W'(wr_en[j]);
        end
    end

    // Next pointer and counter values, with flush trimming the tail.
    always_comb begin
        head_n = drain_fire ? PTR_W'(ring_add(32'(head), 1, DEPTH)) : head;
        rptr_n = (retire_valid && !merge_en) ? PTR_W'(ring_add(32'(rptr), 1, DEPTH)) : rptr;
        rcnt_n = rcnt + CNT_W'(retire_valid && !merge_en) - CNT_W'(drain_fire);
        if (flush) begin
            tail_n = rptr_n;
            cnt_n  = rcnt_n;
        end else begin
            tail_n = PTR_W'(ring_add(32'(base_idx), 32'(n_alloc), DEPTH));
            cnt_n  = cnt + CNT_W'(n_alloc) - CNT_W'(merge_en) - CNT_W'(drain_fire);
        end
    end

    // Pointer and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            rptr <= '0;
            tail <= '0;
            cnt  <= '0;
            rcnt <= '0;
        end else begin
            head <= head_n;
            rptr <= rptr_n;
            tail <= tail_n;
            cnt  <= cnt_n;
            rcnt <= rcnt_n;
        end
    end

    // Entry storage: allocation writes and merge updates (occupancy is in the counters).
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (merge_en && older_idx == PTR_W'(e)) begin
                e_data[e] <= merged_data;
                e_be[e]   <= e_be[e] | e_be[rptr];
            end
            for (int j = 0; j < ALLOC_W; j++) begin
                if (wr_en[j] && slot_idx[j] == PTR_W'(e)) begin
                    e_addr[e] <= wr_addr[j];
                    e_data[e] <= wr_data[j];
                    e_be[e]   <= wr_be[j];
                end
            end
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_W'(DEPTH)) && (rcnt <= cnt));

    // R5
    retire_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (cnt != rcnt));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == rcnt));

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr)));

endmodule

// File: rtl/sb_stall_ctr.sv
`timescale 1ns/1ps
// Module sb_stall_ctr
// Counts allocate cycles lost because no store entry was free.
// Assumes: stall_evt is a single-cycle level for each lost cycle. The
// count wraps at its width.
module sb_stall_ctr #(
    parameter int STALL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_evt,
    output logic [STALL_W-1:0] count
);

    // Increment once per lost cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (stall_evt) count <= count + 1'b1;
    end

    // R4
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |=> (count == STALL_W'($past(count) + 1'b1)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_evt |=> $stable(count));

endmodule

// File: rtl/spec_store_buffer.sv
`timescale 1ns/1ps
// Module spec_store_buffer
// Top of the store buffer. It grants allocate slots against the free
// entries, keeps stores until retired, discards unretired stores on a
// flush, drains retired stores in order to the cache write port and counts
// allocate stall cycles.
// Assumes: the front end re-presents refused micro-ops, and retire_valid
// is raised only while an unretired store is held.
module spec_store_buffer #(
    parameter int DEPTH   = 42,
    parameter int ALLOC_W = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int STALL_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int RK_W   = $clog2(ALLOC_W + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ALLOC_W-1:0]             alloc_valid,
    input  logic [ALLOC_W-1:0]             alloc_store,
    input  logic [ALLOC_W-1:0][ADDR_W-1:0] alloc_addr,
    input  logic [ALLOC_W-1:0][DATA_W-1:0] alloc_data,
    input  logic [ALLOC_W-1:0][BE_W-1:0]   alloc_be,
    output logic [ALLOC_W-1:0]             alloc_grant,
    input  logic                           retire_valid,
    input  logic                           flush,
    output logic                           cache_wr_valid,
    output logic [ADDR_W-1:0]              cache_wr_addr,
    output logic [DATA_W-1:0]              cache_wr_data,
    output logic [BE_W-1:0]                cache_wr_be,
    input  logic                           cache_wr_ready,
    output logic [STALL_W-1:0]             stall_cycles
);

    logic [CNT_W-1:0]             free_slots;
    logic [ALLOC_W-1:0]           wr_en;
    logic [ALLOC_W-1:0][RK_W-1:0] wr_rank;
    logic                         no_space;

    sb_alloc_grant #(
        .ALLOC_W (ALLOC_W),
        .CNT_W   (CNT_W),
        .RK_W    (RK_W)
    ) u_grant (
        .valid      (alloc_valid),
        .is_store   (alloc_store),
        .free_slots (free_slots),
        .block      (flush),
        .grant      (alloc_grant),
        .wr_en      (wr_en),
        .wr_rank    (wr_rank),
        .no_space   (no_space)
    );

    sb_entry_queue #(
        .DEPTH   (DEPTH),
        .ALLOC_W (ALLOC_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BE_W    (BE_W),
        .PTR_W   (PTR_W),
        .CNT_W   (CNT_W),
        .RK_W    (RK_W)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_rank      (wr_rank),
        .wr_addr      (alloc_addr),
        .wr_data      (alloc_data),
        .wr_be        (alloc_be),
        .retire_valid (retire_valid),
        .flush        (flush),
        .drain_ready  (cache_wr_ready),
        .free_slots   (free_slots),
        .drain_valid  (cache_wr_valid),
        .drain_addr   (cache_wr_addr),
        .drain_data   (cache_wr_data),
        .drain_be     (cache_wr_be)
    );

    sb_stall_ctr #(
        .STALL_W (STALL_W)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_evt (no_space),
        .count     (stall_cycles)
    );

    // R2
    grant_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, alloc_grant} + 1'b1) & {1'b0, alloc_grant}) == '0)
        && ((alloc_grant & ~alloc_valid) == '0));

    // R8
    flush_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (alloc_grant == '0));

endmodule

// File: tb/spec_store_buffer_tb.sv
`timescale 1ns/1ps
module spec_store_buffer_tb;
    localparam int DEPTH = 42;
    localparam int AW = 4;
    localparam int ADW = 32;
    localparam int DW = 64;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0]          alloc_valid, alloc_store, alloc_grant;
    logic [AW-1:0][ADW-1:0] alloc_addr;
    logic [AW-1:0][DW-1:0]  alloc_data;
    logic [AW-1:0][BW-1:0]  alloc_be;
    logic retire_valid, flush, cache_wr_valid, cache_wr_ready;
    logic [ADW-1:0] cache_wr_addr;
    logic [DW-1:0]  cache_wr_data;
    logic [BW-1:0]  cache_wr_be;
    logic [31:0]    stall_cycles;

    int total = 0;
    int bad = 0;

    spec_store_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data), .alloc_be(alloc_be),
        .alloc_grant(alloc_grant), .retire_valid(retire_valid), .flush(flush),
        .cache_wr_valid(cache_wr_valid), .cache_wr_addr(cache_wr_addr),
        .cache_wr_data(cache_wr_data), .cache_wr_be(cache_wr_be),
        .cache_wr_ready(cache_wr_ready), .stall_cycles(stall_cycles)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_slots();
        alloc_valid = '0; alloc_store = '0;
        alloc_addr = '0; alloc_data = '0; alloc_be = '0;
    endtask

    task automatic set_slot(input int j, input logic st, input logic [31:0] a,
                            input logic [63:0] d, input logic [7:0] be);
        alloc_valid[j] = 1'b1; alloc_store[j] = st;
        alloc_addr[j] = a; alloc_data[j] = d; alloc_be[j] = be;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clear_slots();
        retire_valid = 1'b0; flush = 1'b0; cache_wr_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Fill n stores with address 8*k and data k; every group fully granted.
    task automatic fill(input int n);
        int k;
        int m;
        k = 0;
        while (k < n) begin
            @(negedge clk); clear_slots();
            m = (n - k > 4) ? 4 : n - k;
            for (int j = 0; j < m; j++) set_slot(j, 1'b1, 32'(8 * (k + j)), 64'(k + j), 8'hFF);
            #1 chk("R2 fill grant", 64'(alloc_grant), 64'((1 << m) - 1));
            k = k + m;
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 grant", 64'(alloc_grant), 64'h0);
        chk("R1 cache valid", 64'(cache_wr_valid), 64'h0);
        chk("R1 stall count", 64'(stall_cycles), 64'h0);
    endtask

    task automatic t_fill_stall();
        do_reset();
        fill(40);
        @(negedge clk); clear_slots();
        for (int j = 0; j < 4; j++) set_slot(j, 1'b1, 32'(8 * (40 + j)), 64'(40 + j), 8'hFF);
        #1 chk("R3 partial grant", 64'(alloc_grant), 64'h3);
        chk("R4 no count yet", 64'(stall_cycles), 64'h0);
        @(negedge clk); clear_slots();
        set_slot(0, 1'b0, 0, 0, 0); set_slot(1, 1'b0, 0, 0, 0);
        set_slot(2, 1'b1, 32'h400, 0, 8'hFF); set_slot(3, 1'b1, 32'h408, 0, 8'hFF);
        #1 chk("R2 non-stores pass when full", 64'(alloc_grant), 64'h3);
        chk("R4 one stall", 64'(stall_cycles), 64'h1);
        @(negedge clk); clear_slots();
        set_slot(0, 1'b0, 0, 0, 0); set_slot(1, 1'b1, 32'h400, 0, 8'hFF);
        set_slot(2, 1'b0, 0, 0, 0); set_slot(3, 1'b0, 0, 0, 0);
        #1 chk("R3 younger held behind store", 64'(alloc_grant), 64'h1);
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); clear_slots();
            for (int j = 0; j < 4; j++) set_slot(j, 1'b1, 32'h500, 0, 8'hFF);
            #1 chk("R3 full no grant", 64'(alloc_grant), 64'h0);
        end
        @(negedge clk); clear_slots();
        #1 chk("R4 five stalls", 64'(stall_cycles), 64'h5);
        @(negedge clk);
        #1 chk("R4 holds when idle", 64'(stall_cycles), 64'h5);
    endtask

    task automatic t_retire_drain();
        do_reset();
        fill(42);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        #1 chk("R5 nothing retired yet", 64'(cache_wr_valid), 64'h0);
        @(negedge clk);
        #1 chk("R5 valid after retire", 64'(cache_wr_valid), 64'h1);
        chk("R6 oldest first", 64'(cache_wr_addr), 64'h0);
        @(negedge clk); retire_valid = 1'b0;
        set_slot(0, 1'b1, 32'h600, 64'h66, 8'hFF);
        #1 chk("R6 held while not ready", 64'(cache_wr_addr), 64'h0);
        chk("R3 full without drain", 64'(alloc_grant), 64'h0);
        @(negedge clk); cache_wr_ready = 1'b1;
        #1 chk("R7 same-cycle reuse", 64'(alloc_grant), 64'h1);
        chk("R6 offered addr", 64'(cache_wr_addr), 64'h0);
        @(negedge clk); clear_slots();
        #1 chk("R6 next in order", 64'(cache_wr_addr), 64'h8);
        chk("R6 data", 64'(cache_wr_data), 64'h1);
        @(negedge clk);
        #1 chk("R5 unretired not offered", 64'(cache_wr_valid), 64'h0);
    endtask

    task automatic t_order();
        do_reset();
        @(negedge clk); clear_slots(); cache_wr_ready = 1'b1;
        set_slot(0, 1'b1, 32'h40, 64'hA0, 8'hFF);
        set_slot(1, 1'b0, 0, 0, 0);
        set_slot(2, 1'b1, 32'h48, 64'hA1, 8'hFF);
        set_slot(3, 1'b1, 32'h50, 64'hA2, 8'hFF);
        #1 chk("R2 mixed group", 64'(alloc_grant), 64'hF);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        #1 chk("R5 idle port", 64'(cache_wr_valid), 64'h0);
        @(negedge clk);
        #1 chk("R2 order 0", 64'(cache_wr_addr), 64'h40);
        @(negedge clk);
        #1 chk("R2 order 1", 64'(cache_wr_addr), 64'h48);
        chk("R2 data 1", 64'(cache_wr_data), 64'hA1);
        @(negedge clk); retire_valid = 1'b0;
        #1 chk("R2 order 2", 64'(cache_wr_addr), 64'h50);
        @(negedge clk);
        #1 chk("R6 empty after drain", 64'(cache_wr_valid), 64'h0);
        chk("R4 no stall", 64'(stall_cycles), 64'h0);
    endtask

    task automatic t_flush();
        do_reset();
        @(negedge clk); clear_slots();
        for (int j = 0; j < 4; j++) set_slot(j, 1'b1, 32'(32'h200 + 8 * j), 64'(j), 8'hFF);
        #1 chk("R2 four stores", 64'(alloc_grant), 64'hF);
        @(negedge clk); retire_valid = 1'b1; flush = 1'b1;
        #1 chk("R8 no grant on flush", 64'(alloc_grant), 64'h0);
        @(negedge clk); clear_slots(); retire_valid = 1'b0; flush = 1'b0; cache_wr_ready = 1'b1;
        #1 chk("R8 retired kept", 64'(cache_wr_addr), 64'h200);
        chk("R8 retired valid", 64'(cache_wr_valid), 64'h1);
        @(negedge clk);
        #1 chk("R8 flushed gone", 64'(cache_wr_valid), 64'h0);
        @(negedge clk); set_slot(0, 1'b1, 32'h300, 64'h33, 8'hFF);
        #1 chk("R8 space after flush", 64'(alloc_grant), 64'h1);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        @(negedge clk); retire_valid = 1'b0;
        #1 chk("R8 new store drains", 64'(cache_wr_addr), 64'h300);
    endtask

    task automatic t_merge();
        do_reset();
        @(negedge clk); clear_slots();
        set_slot(0, 1'b1, 32'h100, 64'h1111_1111_1111_1111, 8'h0F);
        set_slot(1, 1'b1, 32'h100, 64'h2222_2222_2222_2222, 8'h3C);
        #1 chk("R9 grant", 64'(alloc_grant), 64'h3);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        @(negedge clk);
        @(negedge clk); retire_valid = 1'b0; cache_wr_ready = 1'b1;
        #1 chk("R9 addr", 64'(cache_wr_addr), 64'h100);
        chk("R9 be or", 64'(cache_wr_be), 64'h3F);
        chk("R9 data", cache_wr_data, 64'h1111_2222_2222_1111);
        @(negedge clk);
        #1 chk("R9 single write", 64'(cache_wr_valid), 64'h0);
    endtask

    task automatic t_no_merge();
        do_reset();
        @(negedge clk); clear_slots(); cache_wr_ready = 1'b1;
        set_slot(0, 1'b1, 32'h100, 64'h1, 8'h0F);
        set_slot(1, 1'b1, 32'h100, 64'h2, 8'hF0);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        @(negedge clk);
        #1 chk("R10 draining older be", 64'(cache_wr_be), 64'h0F);
        @(negedge clk); retire_valid = 1'b0;
        #1 chk("R10 younger separate", 64'(cache_wr_be), 64'hF0);
        chk("R10 younger valid", 64'(cache_wr_valid), 64'h1);
        do_reset();
        @(negedge clk); clear_slots();
        set_slot(0, 1'b1, 32'h180, 64'h5, 8'h0F);
        set_slot(1, 1'b1, 32'h188, 64'h6, 8'h0F);
        @(negedge clk); clear_slots(); retire_valid = 1'b1;
        @(negedge clk);
        @(negedge clk); retire_valid = 1'b0; cache_wr_ready = 1'b1;
        #1 chk("R10 first addr", 64'(cache_wr_addr), 64'h180);
        @(negedge clk);
        #1 chk("R10 second addr", 64'(cache_wr_addr), 64'h188);
        chk("R10 second data", cache_wr_data, 64'h6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_slots();
        retire_valid = 1'b0; flush = 1'b0; cache_wr_ready = 1'b0;
        t_reset();
        t_fill_stall();
        t_retire_drain();
        t_order();
        t_flush();
        t_merge();
        t_no_merge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule